// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block manages one hot-pluggable expansion slot. Software programs it through a small word-addressed register port that holds three views: a capability word that says which slot hardware is fitted, and a combined control/status word. The block drives three active-low slot outputs (power enable, power indicator LED and slot reset). It watches two active-low inputs: the external power controller's fault line and the retention-latch sensor.

Slot sequencing is gated. While the latch sensor is fitted but the latch is open, every output stays idle. Once the latch closes, power follows the software power command, and the slot reset is released a configurable number of cycles after power is up. Fault and latch-closing events are caught after a two-flop synchronizer and kept in sticky status bits. Software commands that change the power state, and non-reserved indicator writes, post a command-completed event. A single level interrupt request combines the enabled events.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the capability word (address 0) reads 0x00000016, with bit 1 = power controller fitted, bit 2 = latch sensor fitted and bit 4 = indicator fitted. The control/status word (address 1) reads 0x00000100: power command on (bit 10 = 0) and indicator field bits 9:8 = 01. pwr_en_n and pwr_led_n are high, slot_rst_n is low and irq is low.
- R2: While capability bit 2 is 1 and mrl_n is high, pwr_en_n and pwr_led_n stay high and slot_rst_n stays low, whatever the command bits hold. When capability bit 2 is 0, the latch input does not gate the outputs.
- R3: pwr_en_n is low exactly when capability bit 1 is 1, control bit 10 is 0 (0 = on, 1 = off) and the latch gate of R2 is open.
- R4: slot_rst_n goes high SETTLE_CYC cycles after the slot power comes up. It falls in the same cycle that power goes down or the power-fault status bit becomes set.
- R5: pwr_led_n follows the indicator field in bits 9:8: 01 drives it low, 11 drives it high, and 10 toggles it every 2^(BLINK_W-1) cycles. If capability bit 4 is 0, pwr_led_n stays high.
- R6: A write to address 1 with 00 in bits 9:8 leaves the indicator field unchanged and posts no command-completed event for that field.
- R7: Status bit 20 (command completed) is set one cycle after either of two writes: a write that changes control bit 10 while capability bit 1 is 1, or a write of a non-zero indicator value while capability bit 4 is 1.
- R8: Status bit 17 (power fault) is set on a synchronized falling edge of pwr_fault_n only if capability bit 1 is 1. Status bit 18 (latch closed) is set on a synchronized falling edge of mrl_n only if capability bit 2 is 1.
- R9: Status bits are sticky. Writing 1 to bit 17, 18 or 20 of address 1 clears that bit, and writing 0 leaves it. A new event in the same cycle wins over the clear.
- R10: irq = bit5 & ((bit4 & bit20) | (bit1 & bit17)), where bits 1, 4 and 5 are control enables in the address-1 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 capabilities, 1 control/status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pwr_fault_n | input | 1 | Active-low power fault from the slot power controller |
| mrl_n | input | 1 | Active-low retention-latch closed sensor |
| pwr_en_n | output | 1 | Active-low slot power enable |
| pwr_led_n | output | 1 | Active-low power indicator LED |
| slot_rst_n | output | 1 | Active-low slot reset |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that pwr_fault_n and mrl_n are quasi-static compared with the clock. They also assume that a status bit only drops in a cycle carrying a register write. The stimulus therefore holds each input level for at least four cycles, so that the two-flop synchronizer and edge detector see every transition. It changes registers only through single-cycle write strobes issued between clock edges. The enable and status sweeps run without concurrent input edges, so each interrupt expectation depends on one known status pattern only.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  // capability word bit positions
  localparam int CAP_PWR = 1;
  localparam int CAP_MRL = 2;
  localparam int CAP_IND = 4;
  // control half (bits 15:0 of word 1)
  localparam int CTL_PFDE = 1;
  localparam int CTL_CCIE = 4;
  localparam int CTL_HPIE = 5;
  localparam int CTL_IND  = 8;
  localparam int CTL_PWR  = 10;
  // status half (bits 31:16 of word 1), index within the half
  localparam int STS_PFD = 1;
  localparam int STS_MRL = 2;
  localparam int STS_CC  = 4;

  localparam logic [15:0] CAPS_RST   = 16'h0016;
  localparam logic [15:0] CAPS_WMASK = 16'h0016;
  localparam logic [15:0] CTL_RST    = 16'h0100;
  localparam logic [15:0] CTL_WMASK  = 16'h0432;
  localparam logic [15:0] STS_MASK   = 16'h0016;

  typedef enum logic [1:0] {
    IND_KEEP  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= in_n[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl[i]  = ~s2_q;
    assign fall[i] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hp_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        addr,
  input  logic [31:0] wdata,
  input  logic        fault_fall,
  input  logic        mrl_fall,
  output logic [15:0] caps_q,
  output logic [15:0] ctl_q,
  output logic [15:0] sts_q,
  output logic [31:0] rdata,
  output logic        irq
);
  logic [15:0] caps_d, ctl_d, sts_d;
  logic        cc_ev;
  logic        wr_caps, wr_cs;

  assign wr_caps = wr & ~addr;
  assign wr_cs   = wr &  addr;

  always_comb begin
    caps_d = caps_q;
    ctl_d  = ctl_q;
    sts_d  = sts_q;
    cc_ev  = 1'b0;
    if (wr_caps) caps_d = wdata[15:0] & CAPS_WMASK;
    if (wr_cs) begin
      ctl_d = (ctl_q & ~CTL_WMASK) | (wdata[15:0] & CTL_WMASK);
      if (wdata[CTL_IND+1:CTL_IND] != IND_KEEP)
        ctl_d[CTL_IND+1:CTL_IND] = wdata[CTL_IND+1:CTL_IND];
      cc_ev = (caps_q[CAP_PWR] & (wdata[CTL_PWR] != ctl_q[CTL_PWR])) |
              (caps_q[CAP_IND] & (wdata[CTL_IND+1:CTL_IND] != IND_KEEP));
      sts_d = sts_q & ~(wdata[31:16] & STS_MASK);
    end
    if (fault_fall & caps_q[CAP_PWR]) sts_d[STS_PFD] = 1'b1;
    if (mrl_fall & caps_q[CAP_MRL])   sts_d[STS_MRL] = 1'b1;
    if (cc_ev)                        sts_d[STS_CC]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caps_q <= CAPS_RST;
      ctl_q  <= CTL_RST;
      sts_q  <= '0;
    end else begin
      caps_q <= caps_d;
      ctl_q  <= ctl_d;
      sts_q  <= sts_d;
    end
  end

  assign rdata = addr ? {sts_q, ctl_q} : {16'h0000, caps_q};
  assign irq   = ctl_q[CTL_HPIE] &
                 ((ctl_q[CTL_CCIE] & sts_q[STS_CC]) | (ctl_q[CTL_PFDE] & sts_q[STS_PFD]));
endmodule

// File: rtl/hp_outputs.sv
module hp_outputs
  import hp_slot_pkg::*;
#(
  parameter int SETTLE_CYC = 1000,
  parameter int BLINK_W    = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] caps_q,
  input  logic [15:0] ctl_q,
  input  logic        pfd,
  input  logic        mrl_lvl,
  output logic        mrl_ok,
  output logic        pwr_en_n,
  output logic        pwr_led_n,
  output logic        slot_rst_n
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BLINK_W-1:0] blk_q, blk_d;
  logic               blk_en;
  logic               cmd_on, pwr_on, live, done;
  ind_e               ind;

  assign mrl_ok = ~caps_q[CAP_MRL] | mrl_lvl;
  assign cmd_on = ~ctl_q[CTL_PWR];
  assign pwr_on = caps_q[CAP_PWR] ? (cmd_on & mrl_ok) : mrl_ok;
  assign live   = pwr_on & ~pfd;
  assign done   = (cnt_q == CNT_MAX);
  assign ind    = ind_e'(ctl_q[CTL_IND+1:CTL_IND]);
  assign blk_en = 1'b1;

  always_comb begin
    if (!live)     cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + 1'b1;
    blk_d = blk_en ? blk_q + 1'b1 : blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  always_comb begin
    pwr_led_n = 1'b1;
    if (caps_q[CAP_IND] && mrl_ok) begin
      case (ind)
        IND_ON:    pwr_led_n = 1'b0;
        IND_BLINK: pwr_led_n = blk_q[BLINK_W-1];
        default:   pwr_led_n = 1'b1;
      endcase
    end
  end

  assign pwr_en_n   = ~(caps_q[CAP_PWR] & cmd_on & mrl_ok);
  assign slot_rst_n = live & done;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int SETTLE_CYC = 1000,
  parameter int BLINK_W    = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pwr_fault_n,
  input  logic        mrl_n,
  output logic        pwr_en_n,
  output logic        pwr_led_n,
  output logic        slot_rst_n,
  output logic        irq
);
  logic [1:0]  lvl, fall;
  logic [15:0] caps_q, ctl_q, sts_q;
  logic        mrl_ok;

  hp_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .in_n({mrl_n, pwr_fault_n}),
    .lvl(lvl), .fall(fall)
  );

  hp_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .fault_fall(fall[0]), .mrl_fall(fall[1]),
    .caps_q(caps_q), .ctl_q(ctl_q), .sts_q(sts_q),
    .rdata(reg_rdata), .irq(irq)
  );

  hp_outputs #(.SETTLE_CYC(SETTLE_CYC), .BLINK_W(BLINK_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .caps_q(caps_q), .ctl_q(ctl_q),
    .pfd(sts_q[STS_PFD]), .mrl_lvl(lvl[1]),
    .mrl_ok(mrl_ok),
    .pwr_en_n(pwr_en_n), .pwr_led_n(pwr_led_n), .slot_rst_n(slot_rst_n)
  );
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk
  import hp_slot_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        pwr_en_n,
  input logic        pwr_led_n,
  input logic        slot_rst_n,
  input logic        irq,
  input logic [15:0] caps_q,
  input logic [15:0] ctl_q,
  input logic [15:0] sts_q,
  input logic        mrl_ok
);
  p_latch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mrl_ok |-> (pwr_en_n && pwr_led_n && !slot_rst_n));

  p_pwr_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !caps_q[CAP_PWR] |-> pwr_en_n);

  p_rst_needs_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (caps_q[CAP_PWR] && pwr_en_n) |-> !slot_rst_n);

  p_rst_on_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[STS_PFD] |-> !slot_rst_n);

  p_led_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !caps_q[CAP_IND] |-> pwr_led_n);

  p_sticky_pfd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[STS_PFD] && !reg_wr) |=> sts_q[STS_PFD]);

  p_sticky_cc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[STS_CC] && !reg_wr) |=> sts_q[STS_CC]);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl_q[CTL_HPIE] && (sts_q[STS_CC] || sts_q[STS_PFD])));
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
  .pwr_en_n(pwr_en_n), .pwr_led_n(pwr_led_n), .slot_rst_n(slot_rst_n), .irq(irq),
  .caps_q(caps_q), .ctl_q(ctl_q), .sts_q(sts_q), .mrl_ok(mrl_ok)
);

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
  localparam int SETTLE  = 6;
  localparam int BW      = 3;
  localparam int HALFPER = 1 << (BW - 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pwr_fault_n, mrl_n;
  logic        pwr_en_n, pwr_led_n, slot_rst_n, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  hp_slot_ctrl #(.SETTLE_CYC(SETTLE), .BLINK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwr_fault_n(pwr_fault_n), .mrl_n(mrl_n),
    .pwr_en_n(pwr_en_n), .pwr_led_n(pwr_led_n), .slot_rst_n(slot_rst_n), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // control word: pwr_off in bit 10, indicator 9:8, hpie 5, ccie 4, pfde 1
  function automatic logic [31:0] cw(input logic [15:0] clr, input logic off,
                                     input logic [1:0] ind, input logic [2:0] en);
    return {clr, 5'b0, off, ind, 2'b0, en[2], en[1], 2'b0, en[0], 1'b0};
  endfunction

  logic [31:0] d;
  int n, tog;
  logic prev;

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    pwr_fault_n = 1'b1; mrl_n = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(1'b0, d); check("R1 caps", d, 32'h16);
    rd(1'b1, d); check("R1 ctl/status", d, 32'h100);
    check("R1 pwr_en_n", {31'b0, pwr_en_n}, 1);
    check("R1 led", {31'b0, pwr_led_n}, 1);
    check("R1 slot_rst_n", {31'b0, slot_rst_n}, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 idle while latch open
    idle(20);
    check("R2 pwr held off", {31'b0, pwr_en_n}, 1);
    check("R2 rst held", {31'b0, slot_rst_n}, 0);
    check("R2 led held", {31'b0, pwr_led_n}, 1);

    // close latch: R3, R4 settle, R8 latch status
    mrl_n = 1'b0;
    n = 0;
    while (pwr_en_n && n < 10) begin idle(1); n++; end
    check("R3 pwr on after latch", {31'b0, pwr_en_n}, 0);
    n = 0;
    while (!slot_rst_n && n < 50) begin idle(1); n++; end
    check("R4 settle cycles", n, SETTLE);
    rd(1'b1, d); check("R8 latch status bit18", {31'b0, d[18]}, 1);
    check("R5 led on (01)", {31'b0, pwr_led_n}, 0);
    wr(1'b1, cw(16'h0004, 0, 2'b00, 3'b000));
    rd(1'b1, d); check("R9 latch status cleared", {31'b0, d[18]}, 0);

    // R5/R7 indicator sweep
    for (int v = 1; v < 4; v++) begin
      wr(1'b1, cw(16'h0000, 0, v[1:0], 3'b000));
      rd(1'b1, d);
      check("R7 cc after indicator write", {31'b0, d[20]}, 1);
      check("R5 field readback", {30'b0, d[9:8]}, v);
      if (v == 2) begin
        tog = 0; prev = pwr_led_n;
        for (int i = 0; i < 4 * HALFPER; i++) begin
          idle(1);
          if (pwr_led_n != prev) tog++;
          prev = pwr_led_n;
        end
        check("R5 blink toggles", (tog >= 3 && tog <= 4) ? 1 : 0, 1);
      end else begin
        check("R5 steady led", {31'b0, pwr_led_n}, (v == 1) ? 0 : 1);
      end
      wr(1'b1, cw(16'h0010, 0, 2'b00, 3'b000));
      rd(1'b1, d); check("R9 cc cleared", {31'b0, d[20]}, 0);
    end

    // R6 reserved indicator value keeps field (currently 11)
    wr(1'b1, cw(16'h0000, 0, 2'b00, 3'b000));
    rd(1'b1, d);
    check("R6 field kept", {30'b0, d[9:8]}, 3);
    check("R6 no cc", {31'b0, d[20]}, 0);
    wr(1'b1, cw(16'h0000, 0, 2'b01, 3'b000));
    wr(1'b1, cw(16'h0010, 0, 2'b00, 3'b000));

    // R4/R8 fault drops reset
    pwr_fault_n = 1'b0; idle(4); pwr_fault_n = 1'b1; idle(1);
    rd(1'b1, d); check("R8 fault status bit17", {31'b0, d[17]}, 1);
    check("R4 reset on fault", {31'b0, slot_rst_n}, 0);
    idle(3);
    rd(1'b1, d); check("R9 fault status sticky", {31'b0, d[17]}, 1);
    wr(1'b1, cw(16'h0002, 0, 2'b00, 3'b000));
    idle(SETTLE + 1);
    check("R4 reset released after clear", {31'b0, slot_rst_n}, 1);

    // R10 exhaustive enable x status sweep
    for (int s = 0; s < 4; s++) begin
      wr(1'b1, cw(16'h0016, 0, 2'b00, 3'b000));
      if (s[0]) begin
        wr(1'b1, cw(16'h0000, 0, 2'b01, 3'b000));
        wr(1'b1, cw(16'h0004, 0, 2'b00, 3'b000));
      end
      if (s[1]) begin pwr_fault_n = 1'b0; idle(4); pwr_fault_n = 1'b1; idle(4); end
      for (int e = 0; e < 8; e++) begin
        wr(1'b1, cw(16'h0000, 0, 2'b00, e[2:0]));
        check("R10 irq", {31'b0, irq},
              {31'b0, e[2] & ((e[1] & s[0]) | (e[0] & s[1]))});
      end
    end
    wr(1'b1, cw(16'h0016, 0, 2'b00, 3'b000));
    idle(SETTLE + 1);

    // power off command: R3, R4, R7
    wr(1'b1, cw(16'h0000, 1, 2'b00, 3'b000));
    check("R3 pwr off", {31'b0, pwr_en_n}, 1);
    check("R4 reset on power off", {31'b0, slot_rst_n}, 0);
    rd(1'b1, d); check("R7 cc on power change", {31'b0, d[20]}, 1);
    wr(1'b1, cw(16'h0010, 0, 2'b00, 3'b000));
    check("R3 pwr back on", {31'b0, pwr_en_n}, 0);

    // capabilities cleared: R3, R5, R8 gating
    wr(1'b0, 32'h0);
    wr(1'b1, cw(16'h0016, 0, 2'b00, 3'b000));
    check("R3 no controller", {31'b0, pwr_en_n}, 1);
    check("R5 no indicator", {31'b0, pwr_led_n}, 1);
    pwr_fault_n = 1'b0; idle(4); pwr_fault_n = 1'b1;
    mrl_n = 1'b1; idle(4); mrl_n = 1'b0; idle(4);
    rd(1'b1, d);
    check("R8 fault ignored w/o controller", {31'b0, d[17]}, 0);
    check("R8 latch ignored w/o sensor", {31'b0, d[18]}, 0);
    wr(1'b1, cw(16'h0000, 1, 2'b11, 3'b000));
    rd(1'b1, d); check("R7 no cc w/o caps", {31'b0, d[20]}, 0);

    // R2 latch gate removed when sensor absent
    wr(1'b1, cw(16'h0000, 0, 2'b01, 3'b000));
    wr(1'b0, 32'h0000_0012);
    mrl_n = 1'b1; idle(4);
    check("R2 no sensor: pwr on with latch open", {31'b0, pwr_en_n}, 0);
    check("R2 no sensor: led on", {31'b0, pwr_led_n}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule